// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block walks a byte stream of a variable-length instruction format and marks where each instruction starts and ends. Each instruction begins with a one-byte opcode. A small decode table maps the opcode to an operand count between zero and six. Each operand then starts with one specifier byte. Its high nibble names an addressing mode and its low nibble names a register. The mode decides how many extension bytes, such as a displacement, follow before the next operand.

Bytes arrive on a valid/ready pair and the block accepts one byte per cycle. For every accepted byte it produces one-cycle registered pulses in the following cycle. An opcode byte gives a start marker, or an illegal-opcode flag if the opcode is not in the table. A specifier byte gives its mode, register, operand position and a reserved-mode flag. The final byte of an instruction gives an end pulse carrying the total length in bytes. A front end uses these pulses to split the stream into instructions without executing anything.

Top module: `vld_top`

## Requirements
- R1: After a synchronous active-low reset, all pulse outputs are low and the next accepted byte is treated as an opcode.
- R2: The opcode table gives these operand counts: 0x01→0, 0x05→0, 0x16→1, 0xD0→2, 0xC1→3, 0x2C→5, 0xFA→6. A zero-operand opcode gives an end pulse with length 1 in the cycle after it is accepted.
- R3: Any other opcode value raises the illegal pulse for one cycle, with no start marker and no end pulse. The next byte is taken as a new opcode.
- R4: Each accepted specifier byte pulses specifier-valid in the following cycle. The pulse carries mode = bits 7:4, register = bits 3:0, and the operand position counted from 0 within the instruction.
- R5: The number of extension bytes after a specifier is set by its mode nibble: 0x5 (register) and 0x6 (register indirect) take 0, 0xA takes 1, 0xC takes 2, and 0xE takes 4. Extension bytes produce no specifier pulse.
- R6: Every other mode nibble is flagged reserved on the specifier pulse and is followed by no extension bytes.
- R7: In the cycle after the final byte of an instruction is accepted, the end pulse is high for one cycle with the total byte count. The next byte is then taken as an opcode.
- R8: A legal opcode byte gives a one-cycle start marker in the cycle after it is accepted.
- R9: While in_valid is low, no byte is consumed, no pulse is produced, and the decode position does not move.
- R10: The bytes C1 51 C2 E1 02 63 form one instruction of length 6, with operand modes 5, C and 6 at positions 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on in_data is offered |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always high; one byte accepted per cycle |
| sop_o | output | 1 | Start marker for a legal opcode |
| illegal_o | output | 1 | Opcode not in the table |
| spec_valid_o | output | 1 | Specifier fields are valid |
| spec_mode_o | output | 4 | Addressing mode nibble |
| spec_reg_o | output | 4 | Register nibble |
| spec_idx_o | output | 3 | Operand position, starting at 0 |
| spec_rsvd_o | output | 1 | Mode nibble is reserved |
| done_o | output | 1 | Instruction end pulse |
| len_o | output | 6 | Total instruction length in bytes, valid with done_o |

## Verification
A bad operand or extension count inside the decoder shows up at the ports within one instruction. The end pulse lands on the wrong byte or carries a wrong length. From then on the stream is misframed, so a specifier or extension byte is taken as an opcode and the start marker, illegal flag and specifier pulses all diverge. The stimulus mixes every mode, including reserved ones, with illegal opcodes and idle gaps. This way a wrong count or an advance during a gap shows up a few bytes later at most.

// File: rtl/vld_pkg.sv
// Shared types and encodings for the variable-length instruction decoder.
// Assumes one byte per cycle and a mode nibble in the top half of each specifier.
package vld_pkg;
    typedef enum logic [1:0] {
        ST_OP   = 2'd0,
        ST_SPEC = 2'd1,
        ST_EXT  = 2'd2
    } vld_state_e;

    localparam logic [3:0] MODE_REG     = 4'h5;
    localparam logic [3:0] MODE_REG_IND = 4'h6;
    localparam logic [3:0] MODE_DISP8   = 4'hA;
    localparam logic [3:0] MODE_DISP16  = 4'hC;
    localparam logic [3:0] MODE_DISP32  = 4'hE;
endpackage

// File: rtl/vld_opcode_table.sv
// Opcode table: maps an opcode byte to its operand count and a legal flag.
// Assumes every count fits in OPS_W bits; unknown opcodes are marked illegal.
module vld_opcode_table #(
    parameter int OPS_W = 3
) (
    input  logic [7:0]       opcode,
    output logic             legal,
    output logic [OPS_W-1:0] count
);
    // Fixed lookup of supported opcodes.
    always_comb begin
        legal = 1'b1;
        count = '0;
        case (opcode)
            8'h01: count = OPS_W'(0);
            8'h05: count = OPS_W'(0);
            8'h16: count = OPS_W'(1);
            8'hD0: count = OPS_W'(2);
            8'hC1: count = OPS_W'(3);
            8'h2C: count = OPS_W'(5);
            8'hFA: count = OPS_W'(6);
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/vld_spec_decode.sv
// Specifier mode decode: gives the extension byte count for a mode nibble.
// Assumes reserved modes carry no extension bytes.
module vld_spec_decode
    import vld_pkg::*;
#(
    parameter int EXT_W = 3
) (
    input  logic [3:0]       mode,
    output logic [EXT_W-1:0] ext_cnt,
    output logic             rsvd
);
    // Mode nibble to extension length.
    always_comb begin
        rsvd    = 1'b0;
        ext_cnt = '0;
        case (mode)
            MODE_REG, MODE_REG_IND: ext_cnt = EXT_W'(0);
            MODE_DISP8:             ext_cnt = EXT_W'(1);
            MODE_DISP16:            ext_cnt = EXT_W'(2);
            MODE_DISP32:            ext_cnt = EXT_W'(4);
            default:                rsvd    = 1'b1;
        endcase
    end

    // Reserved modes never request extension bytes.
    always_comb begin
        AST_RSVD_NO_EXT: assert (!(rsvd && ext_cnt != '0)); // R6
    end
endmodule

// File: rtl/vld_ctrl.sv
// Decode state machine: tracks the opcode/specifier/extension position,
// counts operands and extension bytes left, and accumulates the length.
// Assumes a byte is consumed in every cycle where in_valid is high.
module vld_ctrl
    import vld_pkg::*;
#(
    parameter int MAX_OPS = 6,
    parameter int LEN_W   = 6,
    parameter int EXT_W   = 3,
    localparam int OPS_W  = $clog2(MAX_OPS + 1),
    localparam int IDX_W  = $clog2(MAX_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             op_legal,
    input  logic [OPS_W-1:0] op_count,
    input  logic [EXT_W-1:0] sd_ext,
    input  logic             sd_rsvd,
    output logic             sop_o,
    output logic             illegal_o,
    output logic             spec_valid_o,
    output logic [3:0]       spec_mode_o,
    output logic [3:0]       spec_reg_o,
    output logic [IDX_W-1:0] spec_idx_o,
    output logic             spec_rsvd_o,
    output logic             done_o,
    output logic [LEN_W-1:0] len_o
);
    vld_state_e       state_q;
    logic [OPS_W-1:0] ops_q;
    logic [EXT_W-1:0] ext_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_acc_q;
    logic [LEN_W-1:0] len_next;

    // Length including the byte being accepted.
    always_comb len_next = len_acc_q + LEN_W'(1);

    // Advance the decode position by one accepted byte and emit pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_OP;
            ops_q        <= '0;
            ext_q        <= '0;
            idx_q        <= '0;
            len_acc_q    <= '0;
            sop_o        <= 1'b0;
            illegal_o    <= 1'b0;
            spec_valid_o <= 1'b0;
            spec_mode_o  <= '0;
            spec_reg_o   <= '0;
            spec_idx_o   <= '0;
            spec_rsvd_o  <= 1'b0;
            done_o       <= 1'b0;
            len_o        <= '0;
        end else begin
            sop_o        <= 1'b0;
            illegal_o    <= 1'b0;
            spec_valid_o <= 1'b0;
            done_o       <= 1'b0;
            if (in_valid) begin
                case (state_q)
                    ST_OP: begin
                        if (!op_legal) begin
                            illegal_o <= 1'b1;
                        end else begin
                            sop_o     <= 1'b1;
                            len_acc_q <= LEN_W'(1);
                            idx_q     <= '0;
                            if (op_count == '0) begin
                                done_o <= 1'b1;
                                len_o  <= LEN_W'(1);
                            end else begin
                                ops_q   <= op_count;
                                state_q <= ST_SPEC;
                            end
                        end
                    end
                    ST_SPEC: begin
                        spec_valid_o <= 1'b1;
                        spec_mode_o  <= in_data[7:4];
                        spec_reg_o   <= in_data[3:0];
                        spec_idx_o   <= idx_q;
                        spec_rsvd_o  <= sd_rsvd;
                        len_acc_q    <= len_next;
                        if (sd_ext != '0) begin
                            ext_q   <= sd_ext;
                            state_q <= ST_EXT;
                        end else if (ops_q == OPS_W'(1)) begin
                            done_o  <= 1'b1;
                            len_o   <= len_next;
                            state_q <= ST_OP;
                        end else begin
                            ops_q <= ops_q - OPS_W'(1);
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    ST_EXT: begin
                        len_acc_q <= len_next;
                        ext_q     <= ext_q - EXT_W'(1);
                        if (ext_q == EXT_W'(1)) begin
                            if (ops_q == OPS_W'(1)) begin
                                done_o  <= 1'b1;
                                len_o   <= len_next;
                                state_q <= ST_OP;
                            end else begin
                                ops_q   <= ops_q - OPS_W'(1);
                                idx_q   <= idx_q + IDX_W'(1);
                                state_q <= ST_SPEC;
                            end
                        end
                    end
                    default: state_q <= ST_OP;
                endcase
            end
        end
    end

    AST_HOLD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_q) && $stable(ops_q) && $stable(ext_q) && !done_o && !sop_o); // R9
    AST_ILLEGAL_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP && in_valid && !op_legal) |=> (state_q == ST_OP) && illegal_o && !sop_o); // R3
    AST_ZERO_OP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OP && in_valid && op_legal && op_count == '0) |=> done_o && (len_o == LEN_W'(1))); // R2
    AST_EXT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT) |-> (ext_q != '0)); // R5
    AST_DONE_TO_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_OP) && (len_o != '0)); // R7
    AST_SPEC_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        spec_valid_o |-> (int'(spec_idx_o) < MAX_OPS) && !sop_o && !illegal_o); // R4
endmodule

// File: rtl/vld_top.sv
// Variable-length instruction length decoder top: wires the opcode table,
// the specifier mode decoder and the control state machine.
// Assumes the consumer never stalls; in_ready is held high.
module vld_top #(
    parameter int MAX_OPS = 6,
    parameter int LEN_W   = 6,
    parameter int EXT_W   = 3,
    localparam int OPS_W  = $clog2(MAX_OPS + 1),
    localparam int IDX_W  = $clog2(MAX_OPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             sop_o,
    output logic             illegal_o,
    output logic             spec_valid_o,
    output logic [3:0]       spec_mode_o,
    output logic [3:0]       spec_reg_o,
    output logic [IDX_W-1:0] spec_idx_o,
    output logic             spec_rsvd_o,
    output logic             done_o,
    output logic [LEN_W-1:0] len_o
);
    logic             op_legal;
    logic [OPS_W-1:0] op_count;
    logic [EXT_W-1:0] sd_ext;
    logic             sd_rsvd;

    // One byte per cycle, never stalled.
    assign in_ready = 1'b1;

    vld_opcode_table #(.OPS_W(OPS_W)) opc_i (
        .opcode (in_data),
        .legal  (op_legal),
        .count  (op_count)
    );

    vld_spec_decode #(.EXT_W(EXT_W)) spd_i (
        .mode    (in_data[7:4]),
        .ext_cnt (sd_ext),
        .rsvd    (sd_rsvd)
    );

    vld_ctrl #(.MAX_OPS(MAX_OPS), .LEN_W(LEN_W), .EXT_W(EXT_W)) ctl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .op_legal     (op_legal),
        .op_count     (op_count),
        .sd_ext       (sd_ext),
        .sd_rsvd      (sd_rsvd),
        .sop_o        (sop_o),
        .illegal_o    (illegal_o),
        .spec_valid_o (spec_valid_o),
        .spec_mode_o  (spec_mode_o),
        .spec_reg_o   (spec_reg_o),
        .spec_idx_o   (spec_idx_o),
        .spec_rsvd_o  (spec_rsvd_o),
        .done_o       (done_o),
        .len_o        (len_o)
    );
endmodule

// File: tb/vld_top_tb_top.sv
module vld_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, sop_o, illegal_o, spec_valid_o, spec_rsvd_o, done_o;
    logic [3:0] spec_mode_o, spec_reg_o;
    logic [2:0] spec_idx_o;
    logic [5:0] len_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model position
    int m_state = 0;
    int m_ops = 0;
    int m_ext = 0;
    int m_len = 0;
    int m_idx = 0;

    always #10 clk = ~clk;

    vld_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .sop_o(sop_o), .illegal_o(illegal_o),
        .spec_valid_o(spec_valid_o), .spec_mode_o(spec_mode_o),
        .spec_reg_o(spec_reg_o), .spec_idx_o(spec_idx_o),
        .spec_rsvd_o(spec_rsvd_o), .done_o(done_o), .len_o(len_o)
    );

    function automatic int tb_ops(input logic [7:0] op);
        case (op)
            8'h01, 8'h05: return 0;
            8'h16: return 1;
            8'hD0: return 2;
            8'hC1: return 3;
            8'h2C: return 5;
            8'hFA: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic int tb_ext(input logic [3:0] mode);
        case (mode)
            4'h5, 4'h6: return 0;
            4'hA: return 1;
            4'hC: return 2;
            4'hE: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit tb_rsvd(input logic [3:0] mode);
        return !(mode == 4'h5 || mode == 4'h6 || mode == 4'hA || mode == 4'hC || mode == 4'hE);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_operand(inout bit e_done, inout int e_len);
        if (m_ops == 1) begin
            e_done = 1'b1;
            e_len  = m_len;
            m_state = 0;
        end else begin
            m_ops--;
            m_idx++;
            m_state = 1;
        end
    endtask

    // Drive one byte, advance the model, check the pulses one cycle later.
    task automatic push(input logic [7:0] b, input string tag);
        bit e_sop = 0, e_ill = 0, e_spec = 0, e_rsvd = 0, e_done = 0;
        int e_len = 0, e_idx = 0, n;
        case (m_state)
            0: begin
                n = tb_ops(b);
                if (n < 0) e_ill = 1'b1;
                else begin
                    e_sop = 1'b1;
                    if (n == 0) begin e_done = 1'b1; e_len = 1; end
                    else begin m_ops = n; m_len = 1; m_idx = 0; m_state = 1; end
                end
            end
            1: begin
                e_spec = 1'b1;
                e_idx  = m_idx;
                e_rsvd = tb_rsvd(b[7:4]);
                m_len++;
                if (tb_ext(b[7:4]) > 0) begin m_ext = tb_ext(b[7:4]); m_state = 2; end
                else finish_operand(e_done, e_len);
            end
            default: begin
                m_len++;
                m_ext--;
                if (m_ext == 0) finish_operand(e_done, e_len);
            end
        endcase
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk(e_ill ? "R3" : "R8", "sop", int'(sop_o), int'(e_sop));
        chk("R3", "illegal", int'(illegal_o), int'(e_ill));
        chk("R7", "done", int'(done_o), int'(e_done));
        chk("R4", "spec_valid", int'(spec_valid_o), int'(e_spec));
        if (e_done) chk(tag, "len", int'(len_o), e_len);
        if (e_spec) begin
            chk("R4", "mode", int'(spec_mode_o), int'(b[7:4]));
            chk("R4", "reg", int'(spec_reg_o), int'(b[3:0]));
            chk("R4", "idx", int'(spec_idx_o), e_idx);
            chk("R6", "rsvd", int'(spec_rsvd_o), int'(e_rsvd));
        end
    endtask

    // Idle cycle: nothing must pulse (R9).
    task automatic idle();
        in_valid = 1'b0;
        in_data  = 8'($urandom);
        @(negedge clk);
        chk("R9", "idle pulses", int'({sop_o, illegal_o, spec_valid_o, done_o}), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [7:0] ops_list [10];
        logic [3:0] mode_list [8];
        seed = $urandom(32'd20240611);
        ops_list = '{8'h01, 8'h05, 8'h16, 8'hD0, 8'hC1, 8'h2C, 8'hFA, 8'h77, 8'h00, 8'h99};
        mode_list = '{4'h5, 4'h6, 4'hA, 4'hC, 4'hE, 4'h3, 4'hF, 4'h0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pulses after reset", int'({sop_o, illegal_o, spec_valid_o, done_o}), 0);

        // R10: worked example, length 6
        push(8'hC1, "R10"); push(8'h51, "R10"); push(8'hC2, "R10");
        push(8'hE1, "R10"); push(8'h02, "R10"); push(8'h63, "R10");
        // R2: zero-operand opcodes back to back
        push(8'h01, "R2"); push(8'h05, "R2");
        // R3: illegal opcode then legal one
        push(8'h77, "R3"); push(8'h16, "R5"); push(8'hE4, "R5");
        push(8'h11, "R5"); push(8'h22, "R5"); push(8'h33, "R5"); push(8'h44, "R5");
        // R6: reserved mode carries no extension
        push(8'hD0, "R6"); push(8'h3A, "R6"); push(8'hA1, "R6"); push(8'h7F, "R6");
        // R9: gaps inside an instruction
        push(8'hD0, "R9"); idle(); push(8'hC2, "R9"); idle(); idle();
        push(8'h10, "R9"); idle(); push(8'h20, "R9"); push(8'h67, "R9");
        // R1: resync check after a clean boundary
        push(8'h05, "R2");

        // Random instruction streams
        for (int k = 0; k < 400; k++) begin
            logic [7:0] op;
            int nops;
            op = ops_list[$urandom_range(0, 9)];
            push(op, "R7");
            nops = tb_ops(op);
            for (int o = 0; o < nops; o++) begin
                logic [3:0] md;
                md = mode_list[$urandom_range(0, 7)];
                if ($urandom_range(0, 3) == 0) idle();
                push({md, 4'($urandom)}, "R7");
                for (int e = 0; e < tb_ext(md); e++) begin
                    if ($urandom_range(0, 4) == 0) idle();
                    push(8'($urandom), "R7");
                end
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule